// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel NOR flash. It looks at write cycles that have already been latched (one address and one data byte per cycle) and picks out the unlock-prefixed command sequences. When a byte program, a chip erase or a sector erase is recognised, it raises a one-cycle start pulse. With that pulse it presents the captured program address and data, or the target sector number. It also raises one-cycle requests for erase suspend and erase resume.

The block tracks the identifier-read mode. While that mode is active, it answers read requests with the manufacturer code, the device code or a per-sector protection flag. The embedded algorithms run outside the block. They report back through two plain flags: `busy_i` is high while an embedded operation is running, and `susp_i` is high while a sector erase is held in suspension.

The write stream is a valid-only stream. There is no ready signal and no back-pressure, and every cycle with `wr_valid` high is consumed in that cycle. The read stream works the same way. Each `rd_valid` produces exactly one `id_valid` beat one cycle later, but only while identifier mode is active.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all start pulses and requests are low, identifier mode is off and `id_valid` is low.
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then (addr, data) raises `prog_start` for one cycle, in the cycle after the fourth write. In that cycle `prog_addr` equals the fourth write's address and `prog_data` equals its data.
- R3: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raises `chip_start` for one cycle, in the cycle after the sixth write.
- R4: The same prefix followed by 30h at any address raises `sect_start` for one cycle. `sect_num` then carries address bits [18:16] of that last write.
- R5: Any write whose address or data does not match the expected next step returns the decoder to the read state, and no pulse follows. Command addresses are compared on bits [10:0] only, so higher bits do not matter.
- R6: AAh@555h, 55h@2AAh, 90h@555h enters identifier mode (`autosel` high). In that mode, a read returns a value chosen by `rd_addr[7:0]`:
  - 00h returns 1Ch.
  - 01h returns the device code (4Fh by default).
  - 02h returns 01h if the sector in `rd_addr[18:16]` has its bit set in `sect_prot`, and 00h otherwise.
  - Any other offset returns 00h.
- R7: Identifier mode persists across any number of reads and writes, and is left only by a write of F0h. Outside identifier mode no `id_valid` beat is produced, and F0h written in the read state has no effect.
- R8: While `busy_i` is high and the last started operation is a program or a chip erase, every write is ignored, B0h included.
- R9: While `busy_i` is high, `susp_i` is low and the running operation is a sector erase, a B0h write at any address raises `susp_req` for one cycle. Every other write is ignored.
- R10: While `susp_i` is high and `busy_i` is low, 30h at any address in the read state raises `resume_req`, and a full program sequence still raises `prog_start`. The identifier-mode command and the erase setup command are rejected.
- R11: A lone 30h write while not suspended, or a resume written after the erase has restarted, produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Latched write cycle present |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| busy_i | input | 1 | Embedded operation running |
| susp_i | input | 1 | Sector erase held in suspension |
| rd_valid | input | 1 | Identifier read request |
| rd_addr | input | 19 | Identifier read address |
| sect_prot | input | 8 | Protection flag per sector |
| prog_start | output | 1 | Program start pulse |
| prog_addr | output | 19 | Captured program address |
| prog_data | output | 8 | Captured program data |
| chip_start | output | 1 | Chip erase start pulse |
| sect_start | output | 1 | Sector erase start pulse |
| sect_num | output | 3 | Captured sector number |
| susp_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| autosel | output | 1 | Identifier mode active |
| id_valid | output | 1 | Identifier read result valid |
| id_data | output | 8 | Identifier read result |

## Verification
The properties assume the external engine is well behaved. It raises `busy_i` only after a start pulse, holds `susp_i` only after a suspend request, and keeps both flags low through reset. The stimulus acts as that engine. It asserts busy in the cycle after each observed start pulse, asserts suspension only after a `susp_req`, and lowers both before the next command outside the busy or suspend scenarios. Random writes keep one write per two clocks and never fall into the one-cycle gap between a start pulse and the busy response.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PROG,
    ST_ESET, ST_EUNL1, ST_EUNL2, ST_ASEL
  } seq_state_t;

  localparam logic [7:0]  CMD_UNL_A = 8'hAA;
  localparam logic [7:0]  CMD_UNL_B = 8'h55;
  localparam logic [7:0]  CMD_IDENT = 8'h90;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ESET  = 8'h80;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_RES   = 8'h30;
  localparam logic [7:0]  CMD_SUSP  = 8'hB0;
  localparam logic [7:0]  CMD_RST   = 8'hF0;
  localparam logic [10:0] ADR_UNL_A = 11'h555;
  localparam logic [10:0] ADR_UNL_B = 11'h2AA;
endpackage

// File: rtl/flash_busy_gate.sv
module flash_busy_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       busy_i,
  input  logic       susp_i,
  input  logic       prog_start_i,
  input  logic       chip_start_i,
  input  logic       sect_start_i,
  input  logic       resume_i,
  output logic       wr_go_o,
  output logic       susp_req_o
);
  import flash_cmd_pkg::*;

  logic prog_last;
  logic erase_sect;
  logic susp_hit;

  // writes reach the sequencer only when no embedded operation runs
  assign wr_go_o  = wr_valid & ~busy_i;
  assign susp_hit = wr_valid & busy_i & ~susp_i & ~prog_last & erase_sect
                    & (wr_data == CMD_SUSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_last  <= 1'b0;
      erase_sect <= 1'b0;
      susp_req_o <= 1'b0;
    end else begin
      susp_req_o <= susp_hit;
      if (prog_start_i)
        prog_last <= 1'b1;
      else if (chip_start_i | sect_start_i | resume_i)
        prog_last <= 1'b0;
      if (sect_start_i)
        erase_sect <= 1'b1;
      else if (chip_start_i)
        erase_sect <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm #(
  parameter int AW = 19,
  parameter int SW = 3,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          susp_i,
  output logic          prog_start_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [7:0]    prog_data_o,
  output logic          chip_start_o,
  output logic          sect_start_o,
  output logic [SW-1:0] sect_num_o,
  output logic          resume_o,
  output logic          asel_o
);
  import flash_cmd_pkg::*;

  seq_state_t st, nxt;
  logic hit_a, hit_b;
  logic p_prog, p_chip, p_sect, p_res;

  assign hit_a = (wr_addr[CW-1:0] == CW'(ADR_UNL_A));
  assign hit_b = (wr_addr[CW-1:0] == CW'(ADR_UNL_B));

  always_comb begin
    nxt    = st;
    p_prog = 1'b0;
    p_chip = 1'b0;
    p_sect = 1'b0;
    p_res  = 1'b0;
    if (wr_go) begin
      case (st)
        ST_READ: begin
          if (hit_a && wr_data == CMD_UNL_A) nxt = ST_UNL1;
          else if (susp_i && wr_data == CMD_RES) p_res = 1'b1;
        end
        ST_UNL1:  nxt = (hit_b && wr_data == CMD_UNL_B) ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          nxt = ST_READ;
          if (hit_a) begin
            if (wr_data == CMD_PROG) nxt = ST_PROG;
            else if (wr_data == CMD_IDENT && !susp_i) nxt = ST_ASEL;
            else if (wr_data == CMD_ESET && !susp_i) nxt = ST_ESET;
          end
        end
        ST_PROG: begin
          nxt    = ST_READ;
          p_prog = 1'b1;
        end
        ST_ESET:  nxt = (hit_a && wr_data == CMD_UNL_A) ? ST_EUNL1 : ST_READ;
        ST_EUNL1: nxt = (hit_b && wr_data == CMD_UNL_B) ? ST_EUNL2 : ST_READ;
        ST_EUNL2: begin
          nxt = ST_READ;
          if (hit_a && wr_data == CMD_CHIP) p_chip = 1'b1;
          else if (wr_data == CMD_SECT) p_sect = 1'b1;
        end
        ST_ASEL:  if (wr_data == CMD_RST) nxt = ST_READ;
        default:  nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_READ;
      prog_start_o <= 1'b0;
      chip_start_o <= 1'b0;
      sect_start_o <= 1'b0;
      resume_o     <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
      sect_num_o   <= '0;
    end else begin
      st           <= nxt;
      prog_start_o <= p_prog;
      chip_start_o <= p_chip;
      sect_start_o <= p_sect;
      resume_o     <= p_res;
      if (p_prog) begin
        prog_addr_o <= wr_addr;
        prog_data_o <= wr_data;
      end
      if (p_sect) sect_num_o <= wr_addr[AW-1 -: SW];
    end
  end

  assign asel_o = (st == ST_ASEL);
endmodule

// File: rtl/flash_id_port.sv
module flash_id_port #(
  parameter int         SW       = 3,
  parameter logic [7:0] MFR_CODE = 8'h1C,
  parameter logic [7:0] DEV_CODE = 8'h4F,
  localparam int        NSECT    = 1 << SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [7:0]       rd_off,
  input  logic [SW-1:0]    rd_sect,
  input  logic             asel,
  input  logic [NSECT-1:0] prot,
  output logic             id_valid_o,
  output logic [7:0]       id_data_o
);
  logic [NSECT-1:0] sel;
  logic             prot_bit;
  logic [7:0]       val;

  for (genvar g = 0; g < NSECT; g++) begin : g_sel
    assign sel[g] = (rd_sect == SW'(g)) & prot[g];
  end
  assign prot_bit = |sel;

  always_comb begin
    case (rd_off)
      8'h00:   val = MFR_CODE;
      8'h01:   val = DEV_CODE;
      8'h02:   val = {7'd0, prot_bit};
      default: val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_valid_o <= 1'b0;
      id_data_o  <= '0;
    end else begin
      id_valid_o <= rd_valid & asel;
      if (rd_valid & asel) id_data_o <= val;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int         AW       = 19,
  parameter int         SW       = 3,
  parameter int         CW       = 11,
  parameter logic [7:0] MFR_CODE = 8'h1C,
  parameter logic [7:0] DEV_CODE = 8'h4F,
  localparam int        NSECT    = 1 << SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             busy_i,
  input  logic             susp_i,
  input  logic             rd_valid,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NSECT-1:0] sect_prot,
  output logic             prog_start,
  output logic [AW-1:0]    prog_addr,
  output logic [7:0]       prog_data,
  output logic             chip_start,
  output logic             sect_start,
  output logic [SW-1:0]    sect_num,
  output logic             susp_req,
  output logic             resume_req,
  output logic             autosel,
  output logic             id_valid,
  output logic [7:0]       id_data
);
  logic wr_go;

  flash_busy_gate u_gate (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .busy_i(busy_i), .susp_i(susp_i), .prog_start_i(prog_start),
    .chip_start_i(chip_start), .sect_start_i(sect_start),
    .resume_i(resume_req), .wr_go_o(wr_go), .susp_req_o(susp_req)
  );

  flash_seq_fsm #(.AW(AW), .SW(SW), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(wr_addr),
    .wr_data(wr_data), .susp_i(susp_i), .prog_start_o(prog_start),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .chip_start_o(chip_start), .sect_start_o(sect_start),
    .sect_num_o(sect_num), .resume_o(resume_req), .asel_o(autosel)
  );

  flash_id_port #(.SW(SW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_off(rd_addr[7:0]),
    .rd_sect(rd_addr[AW-1 -: SW]), .asel(autosel), .prot(sect_prot),
    .id_valid_o(id_valid), .id_data_o(id_data)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW = 19,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          busy_i,
  input logic          susp_i,
  input logic          rd_valid,
  input logic          prog_start,
  input logic          chip_start,
  input logic          sect_start,
  input logic [SW-1:0] sect_num,
  input logic          susp_req,
  input logic          resume_req,
  input logic          autosel,
  input logic          id_valid
);
  assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, chip_start, sect_start, susp_req, resume_req}));
  assert_prog_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  assert_chip_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_start |=> !chip_start);
  assert_sect_num_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sect_start |-> sect_num == $past(wr_addr[AW-1 -: SW]));
  assert_start_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || chip_start || sect_start) |-> $past(wr_valid));
  assert_id_in_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> $past(rd_valid && autosel));
  assert_mode_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(autosel) |-> $past(wr_valid && wr_data == 8'hF0));
  assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> !(prog_start || chip_start || sect_start || resume_req));
  assert_susp_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> $past(busy_i && !susp_i && wr_valid));
  assert_resume_susp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(susp_i && wr_valid));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy_i(busy_i), .susp_i(susp_i), .rd_valid(rd_valid),
  .prog_start(prog_start), .chip_start(chip_start), .sect_start(sect_start),
  .sect_num(sect_num), .susp_req(susp_req), .resume_req(resume_req),
  .autosel(autosel), .id_valid(id_valid)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PROT = 8'b1010_0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, busy_i = 1'b0, susp_i = 1'b0, rd_valid = 1'b0;
  logic [18:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_start, chip_start, sect_start, susp_req, resume_req, autosel, id_valid;
  logic [18:0] prog_addr;
  logic [7:0] prog_data, id_data;
  logic [2:0] sect_num;
  int n_chk = 0, n_bad = 0;
  logic s_prog, s_chip, s_sect, s_susp, s_res;
  logic [18:0] s_paddr;
  logic [7:0] s_pdata;
  logic [2:0] s_snum;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_i(busy_i), .susp_i(susp_i), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .sect_prot(PROT), .prog_start(prog_start),
    .prog_addr(prog_addr), .prog_data(prog_data), .chip_start(chip_start),
    .sect_start(sect_start), .sect_num(sect_num), .susp_req(susp_req),
    .resume_req(resume_req), .autosel(autosel), .id_valid(id_valid),
    .id_data(id_data)
  );

  function automatic logic [7:0] exp_id(input logic [18:0] a);
    case (a[7:0])
      8'h00:   return 8'h1C;
      8'h01:   return 8'h4F;
      8'h02:   return {7'd0, PROT[a[18:16]]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    s_prog = prog_start; s_chip = chip_start; s_sect = sect_start;
    s_susp = susp_req;   s_res = resume_req;
    s_paddr = prog_addr; s_pdata = prog_data; s_snum = sect_num;
    wr_valid = 1'b0;
  endtask

  function automatic logic [4:0] pulses();
    return {s_prog, s_chip, s_sect, s_susp, s_res};
  endfunction

  task automatic unl(input logic [18:0] hi);
    do_wr(hi | 19'h555, 8'hAA);
    do_wr(hi | 19'h2AA, 8'h55);
  endtask

  task automatic seq_prog(input logic [18:0] a, input logic [7:0] d);
    unl(0); do_wr(19'h555, 8'hA0); do_wr(a, d);
  endtask

  task automatic seq_erase(input logic [18:0] a, input logic [7:0] d);
    unl(0); do_wr(19'h555, 8'h80); unl(0); do_wr(a, d);
  endtask

  task automatic do_rd(input logic [18:0] a, output logic v, output logic [7:0] d);
    @(negedge clk); rd_valid = 1'b1; rd_addr = a;
    @(negedge clk); v = id_valid; d = id_data; rd_valid = 1'b0;
  endtask

  task automatic busy_for(input int n);
    busy_i = 1'b1; repeat (n) @(negedge clk); busy_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic v;
    logic [7:0] d;
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pulses", {prog_start, chip_start, sect_start, susp_req, resume_req}, 0);
    chk("R1 autosel/id_valid", {autosel, id_valid}, 0);

    // R2 directed program
    unl(0); chk("R2 no pulse in prefix", pulses(), 0);
    do_wr(19'h555, 8'hA0); chk("R2 no pulse on setup", pulses(), 0);
    do_wr(19'h7ABCD, 8'h5A);
    chk("R2 prog_start", s_prog, 1);
    chk("R2 prog_addr", s_paddr, 19'h7ABCD);
    chk("R2 prog_data", s_pdata, 8'h5A);
    @(negedge clk); chk("R2 single cycle", prog_start, 0);
    busy_for(4);

    // R3 chip erase
    seq_erase(19'h555, 8'h10); chk("R3 chip_start", pulses(), 5'b01000);
    busy_for(3);

    // R4 sector erase
    seq_erase(19'h51234, 8'h30);
    chk("R4 sect_start", pulses(), 5'b00100);
    chk("R4 sect_num", s_snum, 3'd5);
    busy_for(3);

    // R5 wrong address in unlock, then wrong data
    do_wr(19'h555, 8'hAA); do_wr(19'h2AB, 8'h55);
    do_wr(19'h555, 8'hA0); do_wr(19'h01000, 8'h00);
    chk("R5 bad address no prog", pulses(), 0);
    do_wr(19'h555, 8'hAA); do_wr(19'h2AA, 8'h56);
    do_wr(19'h555, 8'hA0); do_wr(19'h01000, 8'h00);
    chk("R5 bad data no prog", pulses(), 0);
    // R5 upper bits ignored in command addresses
    unl(19'h7F800); do_wr(19'h3D555, 8'hA0); do_wr(19'h12345, 8'h33);
    chk("R5 high bits ignored", {s_prog, s_pdata}, {1'b1, 8'h33});
    busy_for(2);

    // R7 identifier reads outside the mode
    do_wr(19'h000, 8'hF0);
    do_rd(19'h00000, v, d); chk("R7 no id outside mode", v, 0);

    // R6 identifier mode
    unl(0); do_wr(19'h555, 8'h90);
    chk("R6 autosel on", autosel, 1);
    do_rd(19'h00000, v, d); chk("R6 mfr", {v, d}, {1'b1, 8'h1C});
    do_rd(19'h40001, v, d); chk("R6 dev", {v, d}, {1'b1, 8'h4F});
    do_rd(19'h10002, v, d); chk("R6 prot s1", {v, d}, {1'b1, 8'h01});
    do_rd(19'h00002, v, d); chk("R6 prot s0", {v, d}, {1'b1, 8'h00});
    do_rd(19'h00005, v, d); chk("R6 other offset", {v, d}, {1'b1, 8'h00});
    for (int i = 0; i < 12; i++) begin
      logic [18:0] a;
      a = {3'($urandom), 8'($urandom), 8'($urandom % 4)};
      do_rd(a, v, d);
      chk("R6 random id", {v, d}, {1'b1, exp_id(a)});
    end
    // R7 writes in mode ignored, F0 exits
    seq_prog(19'h00100, 8'h11);
    chk("R7 writes ignored", {pulses(), autosel}, 6'b000001);
    do_wr(19'h6ABCD, 8'hF0); chk("R7 exit on F0", autosel, 0);
    do_rd(19'h00000, v, d); chk("R7 id off after exit", v, 0);

    // R8 program running: everything ignored
    seq_prog(19'h00200, 8'h22); chk("R8 start", s_prog, 1);
    busy_i = 1'b1;
    do_wr(19'h000, 8'hB0); chk("R8 suspend ignored in program", pulses(), 0);
    seq_prog(19'h00300, 8'h44); chk("R8 program ignored", pulses(), 0);
    busy_i = 1'b0;
    seq_erase(19'h555, 8'h10); chk("R8 chip start", s_chip, 1);
    busy_i = 1'b1;
    do_wr(19'h1234, 8'hB0); chk("R8 suspend ignored in chip erase", pulses(), 0);
    busy_i = 1'b0;
    seq_prog(19'h00400, 8'h55); chk("R8 idle after busy", s_prog, 1);
    busy_for(2);

    // R9 sector erase: only B0 accepted
    seq_erase(19'h2FFFF, 8'h30); chk("R9 sect start", s_snum, 3'd2);
    busy_i = 1'b1;
    do_wr(19'h555, 8'h90); chk("R9 other ignored", pulses(), 0);
    do_wr(19'h7F0F0, 8'hB0); chk("R9 susp_req", pulses(), 5'b00010);
    susp_i = 1'b1; busy_i = 1'b0;

    // R10 suspended behaviour
    unl(0); do_wr(19'h555, 8'h90); chk("R10 ident rejected", autosel, 0);
    seq_erase(19'h555, 8'h10); chk("R10 erase rejected", pulses(), 0);
    seq_prog(19'h60010, 8'h0F); chk("R10 program in suspend", {s_prog, s_paddr}, {1'b1, 19'h60010});
    busy_i = 1'b1;
    do_wr(19'h0, 8'hB0); chk("R10 B0 ignored in suspend-program", pulses(), 0);
    busy_i = 1'b0;
    do_wr(19'h3ABC, 8'h30); chk("R10 resume_req", pulses(), 5'b00001);
    susp_i = 1'b0; busy_i = 1'b1;
    do_wr(19'h0, 8'h30); chk("R11 extra resume ignored", pulses(), 0);
    do_wr(19'h0, 8'hB0); chk("R9 suspend again", s_susp, 1);
    busy_i = 1'b0;

    // R11 lone 30h when not suspended
    do_wr(19'h0, 8'h30); chk("R11 lone resume", pulses(), 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int op;
      logic [18:0] a;
      logic [7:0] dd;
      op = $urandom % 3;
      a = 19'($urandom);
      dd = 8'($urandom);
      if (op == 0) begin
        seq_prog(a, dd);
        chk("R2 random program", {pulses(), s_paddr, s_pdata}, {5'b10000, a, dd});
        busy_for(1 + $urandom % 3);
      end else if (op == 1) begin
        seq_erase(a, 8'h30);
        chk("R4 random sector", {pulses(), s_snum}, {5'b00100, a[18:16]});
        busy_for(1 + $urandom % 3);
      end else begin
        if (dd == 8'hAA) dd = 8'h00;
        do_wr(a, dd); chk("R5 random garbage", pulses(), 0);
      end
    end
    summary();
  end
endmodule